// File: doc/BRIEF.md
# Descriptor Ring Audio DMA Channel

This block is one DMA channel on a peripheral bus. It moves 16-bit audio samples between system memory and a slice of a FIFO that several channels share. Software builds a ring of descriptors in memory. Each descriptor is three 32-bit words at consecutive addresses: a buffer address, an info word and the address of the next descriptor. Software writes the ring head into the descriptor-pointer register. It then writes the control register with the active bit set. From then on the channel walks the ring without further help, and it raises an interrupt each time a descriptor flagged for it has been fully moved.

The control word does three jobs. It places the channel's FIFO window inside the shared storage, with bounds counted in doublewords of four halfwords. It sets a high-water mark, counted in halfwords, which paces memory traffic. It picks the direction. In transmit mode, memory words are split into halfwords and leave on a valid/ready output stream. In receive mode, halfwords enter on a valid/ready input stream and are packed into memory words. The buffer-pointer register can be read at any time to see how far the transfer has gone.

Back-pressure rules: the output stream holds `out_valid` and `out_data` until `out_ready` is seen. The input stream raises `in_ready` only while the window has a free slot. The memory port holds each request until `mem_ready` is seen. Read data is taken in the same cycle as the handshake.

Top module: `adr_dma_channel`

## Requirements
- R1: After reset the control register reads 0, the buffer pointer reads 0, and `mem_valid`, `out_valid` and `in_ready` are all low.
- R2: Register addresses are 0 for the control register, 1 for the descriptor pointer and 2 for the buffer pointer. Read data appears on `reg_rdata` one cycle after `reg_rd`. Control-register bit layout:
  - bit 0: interrupt status (read-only)
  - bit 1: halfword-order select (LD)
  - bit 2: receive
  - bit 3: real-time
  - bit 4: active
  - bits 15:8: high-water mark
  - bits 23:16: window begin
  - bits 31:24: window end

  All of these fields read back as written.
- R3: Writing the control register with active set does three things: it loads the ring head from the descriptor pointer, it empties the window, and it starts the channel. The channel reads the descriptor words at p, p+4 and p+8. Word p+4 carries the interrupt enable in bit 31 and the byte count in bits 15:0. The channel moves the buffer one word at a time at increasing addresses, then follows the next pointer, so a ring repeats forever.
- R4: Writing the control register with active clear stops the channel and empties the window. From the next cycle, `mem_valid`, `out_valid` and `in_ready` stay low and the active bit reads 0.
- R5: In transmit mode, a memory read is issued only while the fill is below the high-water mark and at least two slots are free.
- R6: In receive mode, a memory write is issued only once the fill has reached the high-water mark and holds at least two halfwords.
- R7: With LD set, the first halfword of a memory word is bits 31:16. With LD clear, it is bits 15:0. Receive packing uses the same order.
- R8: When a descriptor with interrupt enable has been fully moved, the interrupt status is set in the following cycle and `irq` goes high. A control-register read clears the status, but a set in the same cycle wins over the clear.
- R9: The buffer-pointer register returns the address of the next word to be moved in the current buffer.
- R10: The window occupies halfword slots begin×4 up to end×4 of the shared storage and acts as a circular FIFO. The data order is the same for any placement.
- R11: The output stream is valid only while the channel is active in transmit mode and the window is not empty. The input stream is ready only while the channel is active in receive mode and the window is not full. Both streams obey the valid/ready back-pressure rules above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| irq | output | 1 | Interrupt status |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with the handshake |
| out_valid | output | 1 | Transmit sample valid |
| out_ready | input | 1 | Transmit sample accepted |
| out_data | output | 16 | Transmit sample |
| in_valid | input | 1 | Receive sample valid |
| in_ready | output | 1 | Receive sample accepted |
| in_data | input | 16 | Receive sample |

## Verification
Two events can land on the same edge, and each case is checked.

The first is a flagged descriptor finishing while software reads the control register. To provoke it, the bench reads the control register on every cycle for the whole of each transmit run. Each run covers both ring descriptors exactly once, and only one of them is flagged. The status must therefore be seen set in exactly one read: a lost set shows as zero reads, and a missing clear shows as several.

The second is the memory side pushing a word into the window in the same cycle that the stream side pops a halfword. Running the consumer continuously, and again with stalls on both sides, forces this case. The stream contents, checked in order, catch any slot that is lost or doubled.

// File: rtl/adr_pkg.sv
package adr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_D_BUF,
    ST_D_CNT,
    ST_D_NXT,
    ST_MOVE
  } eng_st_e;

  localparam int CTL_IRQ     = 0;
  localparam int CTL_LD      = 1;
  localparam int CTL_RCV     = 2;
  localparam int CTL_RT      = 3;
  localparam int CTL_ACT     = 4;
  localparam int CTL_HWM_LSB = 8;
  localparam int CTL_BEG_LSB = 16;
  localparam int CTL_END_LSB = 24;
  localparam int INFO_IE_BIT = 31;
  localparam int CNT_W       = 16;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_DPTR = 2'd1;
  localparam logic [1:0] RA_BPTR = 2'd2;
endpackage

// File: rtl/adr_win_fifo.sv
module adr_win_fifo #(
  parameter int SLOTS = 32,
  parameter int DW = 16,
  localparam int PW = $clog2(SLOTS),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [PW-1:0] win_base,
  input  logic [CW-1:0] win_len,
  input  logic [1:0]    push_n,
  input  logic [DW-1:0] push_d0,
  input  logic [DW-1:0] push_d1,
  input  logic [1:0]    pop_n,
  output logic [DW-1:0] head0,
  output logic [DW-1:0] head1,
  output logic [CW-1:0] fill
);
  logic [DW-1:0] store [SLOTS];
  logic [CW-1:0] wr_off, rd_off, wr_nx, rd_nx, wr_adv, rd_adv;

  function automatic logic [CW-1:0] adv(input logic [CW-1:0] off,
                                        input logic [1:0] k,
                                        input logic [CW-1:0] len);
    logic [CW:0] s;
    s = {1'b0, off} + {{(CW-1){1'b0}}, k};
    if (s >= {1'b0, len}) s = s - {1'b0, len};
    return s[CW-1:0];
  endfunction

  always_comb begin
    wr_nx  = adv(wr_off, 2'd1, win_len);
    rd_nx  = adv(rd_off, 2'd1, win_len);
    wr_adv = adv(wr_off, push_n, win_len);
    rd_adv = adv(rd_off, pop_n, win_len);
    head0  = store[win_base + rd_off[PW-1:0]];
    head1  = store[win_base + rd_nx[PW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!flush && push_n != 2'd0) store[win_base + wr_off[PW-1:0]] <= push_d0;
    if (!flush && push_n == 2'd2) store[win_base + wr_nx[PW-1:0]] <= push_d1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off <= '0;
      rd_off <= '0;
      fill   <= '0;
    end else if (flush) begin
      wr_off <= '0;
      rd_off <= '0;
      fill   <= '0;
    end else begin
      wr_off <= wr_adv;
      rd_off <= rd_adv;
      fill   <= fill + CW'(push_n) - CW'(pop_n);
    end
  end

  AST_FILL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= win_len); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(fill)); // R11
endmodule

// File: rtl/adr_desc_engine.sv
module adr_desc_engine
  import adr_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          halt,
  input  logic [AW-1:0] ring_head,
  input  logic          rcv,
  input  logic          ld,
  input  logic [7:0]    hwm,
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] win_len,
  input  logic [15:0]   head0,
  input  logic [15:0]   head1,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [1:0]    push_n,
  output logic [15:0]   push_d0,
  output logic [15:0]   push_d1,
  output logic [1:0]    pop_n,
  output logic          irq_set,
  output logic [AW-1:0] cur_buf
);
  eng_st_e state;
  logic [AW-1:0] desc_ptr, nxt_ptr;
  logic [CNT_W-1:0] remain;
  logic ie, tx_go, rx_go, fire;

  always_comb begin
    tx_go = (int'(fill) < int'(hwm)) && (int'(fill) + 2 <= int'(win_len));
    rx_go = (int'(fill) >= int'(hwm)) && (int'(fill) >= 2);
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_ptr;
    mem_wdata = ld ? {head0, head1} : {head1, head0};
    push_d0   = ld ? mem_rdata[31:16] : mem_rdata[15:0];
    push_d1   = ld ? mem_rdata[15:0] : mem_rdata[31:16];
    push_n    = 2'd0;
    pop_n     = 2'd0;
    irq_set   = 1'b0;
    if (!halt && !start) begin
      unique case (state)
        ST_D_BUF: mem_valid = 1'b1;
        ST_D_CNT: begin mem_valid = 1'b1; mem_addr = desc_ptr + AW'(4); end
        ST_D_NXT: begin mem_valid = 1'b1; mem_addr = desc_ptr + AW'(8); end
        ST_MOVE: begin
          mem_addr = cur_buf;
          if (remain == '0) irq_set = ie;
          else if (rcv && rx_go) begin
            mem_valid = 1'b1;
            mem_we    = 1'b1;
            if (mem_ready) pop_n = 2'd2;
          end else if (!rcv && tx_go) begin
            mem_valid = 1'b1;
            if (mem_ready) push_n = 2'd2;
          end
        end
        default: ;
      endcase
    end
    fire = mem_valid && mem_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      desc_ptr <= '0;
      nxt_ptr  <= '0;
      cur_buf  <= '0;
      remain   <= '0;
      ie       <= 1'b0;
    end else if (halt) begin
      state <= ST_IDLE;
    end else if (start) begin
      desc_ptr <= ring_head;
      state    <= ST_D_BUF;
    end else begin
      unique case (state)
        ST_D_BUF: if (fire) begin cur_buf <= AW'(mem_rdata); state <= ST_D_CNT; end
        ST_D_CNT: if (fire) begin
          remain <= mem_rdata[CNT_W-1:0];
          ie     <= mem_rdata[INFO_IE_BIT];
          state  <= ST_D_NXT;
        end
        ST_D_NXT: if (fire) begin nxt_ptr <= AW'(mem_rdata); state <= ST_MOVE; end
        ST_MOVE: begin
          if (remain == '0) begin
            desc_ptr <= nxt_ptr;
            state    <= ST_D_BUF;
          end else if (fire) begin
            cur_buf <= cur_buf + AW'(4);
            remain  <= (remain < CNT_W'(4)) ? '0 : remain - CNT_W'(4);
          end
        end
        default: ;
      endcase
    end
  end

  AST_TX_BELOW_HWM: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && state == ST_MOVE) |-> (int'(fill) < int'(hwm))); // R5
  AST_RX_AT_HWM: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (int'(fill) >= int'(hwm) && int'(fill) >= 2)); // R6
endmodule

// File: rtl/adr_dma_channel.sv
module adr_dma_channel
  import adr_pkg::*;
#(
  parameter int AW = 32,
  parameter int FIFO_DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   out_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [15:0]   in_data
);
  localparam int SLOTS = FIFO_DW * 4;
  localparam int PW = $clog2(SLOTS);
  localparam int CW = PW + 1;

  logic [7:0] ctl_hwm, ctl_beg, ctl_end;
  logic ctl_ld, ctl_rcv, ctl_rt, act, irq_q;
  logic [AW-1:0] dptr_q, cur_buf;
  logic ctrl_wr, ctrl_rd, start, halt, irq_set;
  logic [PW-1:0] win_base;
  logic [CW-1:0] win_len, fill;
  logic [7:0] len_dw;
  logic [1:0] e_push_n, e_pop_n, f_push_n, f_pop_n;
  logic [15:0] e_d0, e_d1, f_d0, head0, head1;

  always_comb begin
    ctrl_wr  = reg_wr && reg_addr == RA_CTRL;
    ctrl_rd  = reg_rd && reg_addr == RA_CTRL;
    start    = ctrl_wr && reg_wdata[CTL_ACT];
    halt     = ctrl_wr && !reg_wdata[CTL_ACT];
    len_dw   = ctl_end - ctl_beg;
    win_len  = CW'({len_dw, 2'b00});
    win_base = PW'({ctl_beg, 2'b00});
    out_valid = act && !ctl_rcv && fill != '0;
    in_ready  = act && ctl_rcv && fill < win_len;
    out_data  = head0;
    f_push_n = ctl_rcv ? {1'b0, in_valid && in_ready} : e_push_n;
    f_d0     = ctl_rcv ? in_data : e_d0;
    f_pop_n  = ctl_rcv ? e_pop_n : {1'b0, out_valid && out_ready};
    irq      = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_hwm <= '0; ctl_beg <= '0; ctl_end <= '0;
      ctl_ld <= 1'b0; ctl_rcv <= 1'b0; ctl_rt <= 1'b0;
      act <= 1'b0; irq_q <= 1'b0; dptr_q <= '0; reg_rdata <= '0;
    end else begin
      if (ctrl_wr) begin
        ctl_hwm <= reg_wdata[CTL_HWM_LSB +: 8];
        ctl_beg <= reg_wdata[CTL_BEG_LSB +: 8];
        ctl_end <= reg_wdata[CTL_END_LSB +: 8];
        ctl_ld  <= reg_wdata[CTL_LD];
        ctl_rcv <= reg_wdata[CTL_RCV];
        ctl_rt  <= reg_wdata[CTL_RT];
        act     <= reg_wdata[CTL_ACT];
      end
      if (reg_wr && reg_addr == RA_DPTR) dptr_q <= AW'(reg_wdata);
      if (irq_set) irq_q <= 1'b1;
      else if (ctrl_rd) irq_q <= 1'b0;
      if (reg_rd) begin
        unique case (reg_addr)
          RA_CTRL: reg_rdata <= {ctl_end, ctl_beg, ctl_hwm, 3'b000,
                                 act, ctl_rt, ctl_rcv, ctl_ld, irq_q};
          RA_DPTR: reg_rdata <= 32'(dptr_q);
          RA_BPTR: reg_rdata <= 32'(cur_buf);
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  adr_win_fifo #(.SLOTS(SLOTS), .DW(16)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(ctrl_wr),
    .win_base(win_base), .win_len(win_len),
    .push_n(f_push_n), .push_d0(f_d0), .push_d1(e_d1),
    .pop_n(f_pop_n), .head0(head0), .head1(head1), .fill(fill)
  );

  adr_desc_engine #(.AW(AW), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt),
    .ring_head(dptr_q), .rcv(ctl_rcv), .ld(ctl_ld), .hwm(ctl_hwm),
    .fill(fill), .win_len(win_len), .head0(head0), .head1(head1),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .push_n(e_push_n), .push_d0(e_d0), .push_d1(e_d1), .pop_n(e_pop_n),
    .irq_set(irq_set), .cur_buf(cur_buf)
  );

  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq); // R8
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!mem_valid && !out_valid && !in_ready)); // R4
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !ctrl_wr) |=> (out_valid && $stable(out_data))); // R11
endmodule

// File: tb/adr_dma_channel_tb_top.sv
module adr_dma_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VEC [4] = '{
    32'h02_00_04_02,  // ld=1, no stall, playback slot
    32'h02_00_04_80,  // ld=0, stall
    32'h04_02_04_82,  // ld=1, stall, record slot
    32'h02_01_02_00   // ld=0, mono window of one doubleword
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, mem_valid, mem_ready = 1'b1, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic out_valid, out_ready = 1'b0, in_valid = 1'b0, in_ready;
  logic [15:0] out_data, in_data = '0;
  logic [31:0] mem [256];
  int n_tests = 0, n_fail = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  adr_dma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_valid && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  // Ring: desc0 at 0x00 -> buffer 0x100 (8 bytes), desc1 at 0x0C -> buffer 0x110 (8 bytes, IE).
  task automatic load_ring(input bit rx);
    for (int i = 0; i < 256; i++) mem[i] = {8'hA0, 8'(i), 8'hB0, 8'(i)};
    mem[0] = 32'h100; mem[1] = 32'd8; mem[2] = 32'h0C;
    mem[3] = 32'h110; mem[4] = 32'h8000_0008; mem[5] = rx ? 32'h18 : 32'h00;
    mem[6] = 32'h120; mem[7] = 32'd64; mem[8] = 32'h18;
  endtask

  function automatic logic [15:0] exp_half(input int n, input bit ld);
    int w;
    w = (n / 2 < 2) ? 64 + n / 2 : 66 + n / 2;
    if ((n % 2 == 0) == ld) return {8'hA0, 8'(w)};
    return {8'hB0, 8'(w)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int got, irq_seen, k, guard;
    bit ld, stall, rd_pend;
    load_ring(0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check(!mem_valid && !out_valid && !in_ready, "R1 idle outputs", {mem_valid, out_valid, in_ready}, 0);
    reg_read(2'd0, rd); check(rd == 0, "R1 ctrl after reset", rd, 0);
    reg_read(2'd2, rd); check(rd == 0, "R1 bptr after reset", rd, 0);

    // Vector table: transmit runs, polling the control register every cycle.
    for (int v = 0; v < 4; v++) begin
      ld = VEC[v][1]; stall = VEC[v][7];
      load_ring(0);
      reg_write(2'd1, 32'h0);
      reg_write(2'd0, (VEC[v] & 32'hFFFF_FF7F) | 32'h10);
      got = 0; irq_seen = 0; rd_pend = 0; guard = 0;
      while ((got < 8 || guard < 8) && guard < 4000) begin
        @(negedge clk);
        if (rd_pend && reg_rdata[0]) irq_seen++;
        mem_ready = !(stall && (guard % 3 == 1));
        out_ready = (got < 8) && !(stall && (guard % 2 == 1));
        if (out_valid && out_ready) begin
          // R7 R10 R11: order, placement and back-pressure
          check(out_data == exp_half(got, ld), "R7/R10/R11 tx halfword", 32'(out_data), 32'(exp_half(got, ld)));
          got++;
        end
        reg_rd = 1; reg_addr = 2'd0; rd_pend = 1;
        if (got == 8) guard++; else if (guard < 3000) guard = guard + 0;
        if (got < 8) guard = 0;
      end
      @(negedge clk); reg_rd = 0; out_ready = 0; mem_ready = 1;
      check(got == 8, "R3 ring data delivered", got, 8);
      check(irq_seen == 1, "R8 irq seen once per flagged descriptor", irq_seen, 1);
      reg_write(2'd0, 32'h0);
    end

    // R9 R5: buffer pointer with stalled consumer
    load_ring(0);
    reg_write(2'd1, 32'h0);
    reg_write(2'd0, 32'h02_00_04_12);
    repeat (20) @(negedge clk);
    reg_read(2'd2, rd); check(rd == 32'h110, "R9/R5 bptr halts at high-water", rd, 32'h110);
    check(out_valid && out_data == 16'hA040, "R7 first halfword", 32'(out_data), 32'hA040);
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0;
    repeat (5) @(negedge clk);
    reg_read(2'd2, rd); check(rd == 32'h114, "R9 bptr advances one word", rd, 32'h114);

    // R4: stop
    reg_write(2'd0, 32'h0);
    check(!mem_valid && !out_valid && !in_ready, "R4 quiet after stop", {mem_valid, out_valid, in_ready}, 0);
    repeat (3) @(negedge clk);
    check(!mem_valid, "R4 no memory request", mem_valid, 0);
    reg_read(2'd0, rd); check(rd == 0, "R4 ctrl reads stopped", rd, 0);

    // R6 R3: receive into the ring (record slot window)
    load_ring(1);
    reg_write(2'd1, 32'h0);
    reg_write(2'd0, 32'h04_02_04_16);
    k = 0; guard = 0;
    while (k < 12 && guard < 4000) begin
      @(negedge clk); guard++;
      in_valid = 1; in_data = 16'h5000 + 16'(k);
      if (in_ready) k++;
    end
    @(negedge clk); in_valid = 0;
    repeat (30) @(negedge clk);
    check(mem[64] == 32'h5000_5001, "R6/R7 rx word 0", mem[64], 32'h5000_5001);
    check(mem[65] == 32'h5002_5003, "R6 rx word 1", mem[65], 32'h5002_5003);
    check(mem[68] == 32'h5004_5005, "R3 rx next descriptor word 0", mem[68], 32'h5004_5005);
    check(mem[69] == 32'h5006_5007, "R3 rx next descriptor word 1", mem[69], 32'h5006_5007);
    reg_read(2'd0, rd); check(rd[0] == 1'b1, "R8 rx irq status", 32'(rd[0]), 1);
    reg_read(2'd0, rd); check(rd[0] == 1'b0, "R8 read clears status", 32'(rd[0]), 0);

    // R2: field readback on an inactive write
    reg_write(2'd0, 32'h3311_060E);
    reg_read(2'd0, rd); check(rd == 32'h3311_060E, "R2 field readback", rd, 32'h3311_060E);
    reg_write(2'd1, 32'h0000_ABC0);
    reg_read(2'd1, rd); check(rd == 32'h0000_ABC0, "R2 descriptor pointer readback", rd, 32'hABC0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule